// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block sends the header of a LIN frame from the master side of a bus. One write of an identifier byte starts the whole header with no further command. The block drives a 13-bit dominant break and a one-bit recessive delimiter. It then sends the sync character and the identifier character. Both characters carry one start bit (0) and one stop bit (1), with the least significant bit first. Bit timing comes from an external baud tick enable, and each serial bit lasts exactly one tick.

A ready flag shows when the identifier slot can take a new byte. Two sticky status flags report that the break has completed and that the identifier has completed, and a clear strobe resets both. Parity generation is optional. When it is selected, the two top identifier bits are replaced by computed parity before transmission.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 1, and `brk_flag` and `id_flag` are 0.
- R2: While no header is in progress, `txd` stays 1, even when `baud_tick` pulses.
- R3: A cycle with `id_we`=1 while idle starts a header, and `tx_rdy` is 0 from the next cycle.
- R4: Counting the baud ticks after the write as 1, 2, 3 and so on, ticks 1 to 13 drive `txd`=0 (break) and tick 14 drives `txd`=1 (delimiter).
- R5: Ticks 15 to 24 send the sync character 0x55. Tick 15 is the start bit (0), ticks 16 to 23 are data bits 0 to 7, and tick 24 is the stop bit (1).
- R6: Ticks 25 to 34 send the identifier character in the same framing: start bit at tick 25, bits 0 to 7 at ticks 26 to 33, stop bit at tick 34. Tick 35 ends the header and leaves `txd`=1.
- R7: With `pid_en`=1 at the write, bit 6 of the sent byte is ID0^ID1^ID2^ID4 and bit 7 is ~(ID1^ID3^ID4^ID5), with bits 0 to 5 unchanged. With `pid_en`=0, the byte goes out exactly as written.
- R8: `tx_rdy` returns to 1 at tick 25, when the identifier character is loaded for sending.
- R9: `brk_flag` is set at tick 15 and `id_flag` is set at tick 35. Each stays 1 until a cycle with `sta_clr`=1. If a set and a clear fall on the same cycle, the set wins.
- R10: A write to `id_we` while a header is in progress is ignored. It has no effect on the bits sent, on the header length or on `tx_rdy`.
- R11: `txd` changes only on cycles with `baud_tick`=1, and it holds its value across cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-time enable |
| id_we | input | 1 | Identifier write strobe |
| id_wdata | input | 8 | Identifier byte |
| pid_en | input | 1 | Replace bits 7:6 with parity when 1 |
| sta_clr | input | 1 | Clear both status flags |
| txd | output | 1 | Serial line, idle 1 |
| tx_rdy | output | 1 | Identifier slot free |
| brk_flag | output | 1 | Break (with delimiter) completed |
| id_flag | output | 1 | Identifier character completed |

## Verification
Every serial bit is registered, so the bit for tick k appears in the cycle after the k-th `baud_tick` edge. The bench raises the tick on a falling edge and reads `txd` on the next falling edge. `tx_rdy` drops one cycle after the write. `brk_flag`, `tx_rdy` (rising) and `id_flag` follow the edges of ticks 15, 25 and 35, so the bench reads each flag in the same half-cycle window after the corresponding tick. Between ticks, an idle cycle is inserted and `txd` is read again, which shows that the line holds its value between ticks.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

   typedef enum logic [2:0] {
      PH_BREAK = 3'd0,
      PH_DELIM = 3'd1,
      PH_SYNC  = 3'd2,
      PH_IDENT = 3'd3,
      PH_END   = 3'd4
   } lin_phase_e;

   localparam int LIN_MIN_BREAK = 13;
   localparam int LIN_ID_W      = 8;

endpackage

// File: rtl/lin_pid_gen.sv
module lin_pid_gen #(
   parameter bit PID_SUPPORT = 1'b1
) (
   input  logic       pid_en,
   input  logic [7:0] raw_id,
   output logic [7:0] tx_id
);
   generate
      if (PID_SUPPORT) begin : g_pid
         logic par_lo;
         logic par_hi;
         // even parity over bits 0,1,2,4 ; odd parity over bits 1,3,4,5
         assign par_lo = raw_id[0] ^ raw_id[1] ^ raw_id[2] ^ raw_id[4];
         assign par_hi = ~(raw_id[1] ^ raw_id[3] ^ raw_id[4] ^ raw_id[5]);
         assign tx_id  = pid_en ? {par_hi, par_lo, raw_id[5:0]} : raw_id;
      end else begin : g_raw
         assign tx_id = raw_id;
      end
   endgenerate
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
   import lin_hdr_pkg::*;
#(
   parameter int              BREAK_LEN = 13,
   parameter int              DELIM_LEN = 1,
   parameter int              CHAR_W    = 8,
   parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              baud_tick,
   input  logic [CHAR_W-1:0] id_char,
   output logic              busy,
   output logic              txd,
   output logic              brk_evt,
   output logic              load_evt,
   output logic              done_evt
);
   localparam int FRAME_LEN = CHAR_W + 2;
   localparam int SYNC_OFS  = BREAK_LEN + DELIM_LEN;
   localparam int ID_OFS    = SYNC_OFS + FRAME_LEN;
   localparam int LAST_OFS  = ID_OFS + FRAME_LEN;
   localparam int SLOT_W    = $clog2(LAST_OFS + 1);
   localparam logic [SLOT_W-1:0] SYNC_AT = SLOT_W'(SYNC_OFS);
   localparam logic [SLOT_W-1:0] ID_AT   = SLOT_W'(ID_OFS);

   logic [SLOT_W-1:0] slot_q;
   logic [CHAR_W-1:0] id_q;
   lin_phase_e        phase;
   logic              line_bit;
   logic              step;

   function automatic logic frame_bit(input logic [CHAR_W-1:0] ch, input int pos);
      if (pos == 0)
         return 1'b0;
      else if (pos <= CHAR_W)
         return ch[pos-1];
      else
         return 1'b1;
   endfunction

   // phase decode of the current slot index
   always_comb begin
      int s;
      s = int'(slot_q);
      if (s < BREAK_LEN)
         phase = PH_BREAK;
      else if (s < SYNC_OFS)
         phase = PH_DELIM;
      else if (s < ID_OFS)
         phase = PH_SYNC;
      else if (s < LAST_OFS)
         phase = PH_IDENT;
      else
         phase = PH_END;
   end

   always_comb begin
      int s;
      s = int'(slot_q);
      unique case (phase)
         PH_BREAK: line_bit = 1'b0;
         PH_DELIM: line_bit = 1'b1;
         PH_SYNC:  line_bit = frame_bit(SYNC_CHAR, s - SYNC_OFS);
         PH_IDENT: line_bit = frame_bit(id_q, s - ID_OFS);
         default:  line_bit = 1'b1;
      endcase
   end

   assign step     = busy && baud_tick;
   assign brk_evt  = step && (slot_q == SYNC_AT);
   assign load_evt = step && (slot_q == ID_AT);
   assign done_evt = step && (phase == PH_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         slot_q <= '0;
         txd    <= 1'b1;
         id_q   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            slot_q <= '0;
            id_q   <= id_char;
         end
      end else if (baud_tick) begin
         if (phase == PH_END) begin
            busy   <= 1'b0;
            slot_q <= '0;
            txd    <= 1'b1;
         end else begin
            txd    <= line_bit;
            slot_q <= slot_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lin_hdr_flags.sv
module lin_hdr_flags #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic load_evt,
   input  logic brk_evt,
   input  logic done_evt,
   input  logic sta_clr,
   output logic tx_rdy,
   output logic brk_flag,
   output logic id_flag
);
   logic brk_nx;
   logic id_nx;

   generate
      if (SET_WINS) begin : g_set_first
         assign brk_nx = brk_evt  | (brk_flag & ~sta_clr);
         assign id_nx  = done_evt | (id_flag  & ~sta_clr);
      end else begin : g_clr_first
         assign brk_nx = ~sta_clr & (brk_evt  | brk_flag);
         assign id_nx  = ~sta_clr & (done_evt | id_flag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_rdy   <= 1'b1;
         brk_flag <= 1'b0;
         id_flag  <= 1'b0;
      end else begin
         brk_flag <= brk_nx;
         id_flag  <= id_nx;
         if (accept)
            tx_rdy <= 1'b0;
         else if (load_evt)
            tx_rdy <= 1'b1;
      end
   end
endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
   import lin_hdr_pkg::*;
#(
   parameter int   BREAK_LEN   = 13,
   parameter int   DELIM_LEN   = 1,
   parameter logic [7:0] SYNC_CHAR = 8'h55,
   parameter bit   PID_SUPPORT = 1'b1,
   parameter bit   SET_WINS    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       id_we,
   input  logic [7:0] id_wdata,
   input  logic       pid_en,
   input  logic       sta_clr,
   output logic       txd,
   output logic       tx_rdy,
   output logic       brk_flag,
   output logic       id_flag
);
   localparam int CHAR_W = LIN_ID_W;

   generate
      if (BREAK_LEN < LIN_MIN_BREAK) begin : g_bad_break
         $error("lin_hdr_tx: BREAK_LEN below LIN minimum");
      end
      if (DELIM_LEN < 1) begin : g_bad_delim
         $error("lin_hdr_tx: DELIM_LEN must be at least 1");
      end
   endgenerate

   logic [CHAR_W-1:0] tx_id;
   logic              hdr_busy;
   logic              accept;
   logic              brk_evt;
   logic              load_evt;
   logic              done_evt;

   assign accept = id_we && !hdr_busy;

   lin_pid_gen #(
      .PID_SUPPORT (PID_SUPPORT)
   ) pid_i (
      .pid_en (pid_en),
      .raw_id (id_wdata),
      .tx_id  (tx_id)
   );

   lin_hdr_seq #(
      .BREAK_LEN (BREAK_LEN),
      .DELIM_LEN (DELIM_LEN),
      .CHAR_W    (CHAR_W),
      .SYNC_CHAR (SYNC_CHAR)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (id_we),
      .baud_tick (baud_tick),
      .id_char   (tx_id),
      .busy      (hdr_busy),
      .txd       (txd),
      .brk_evt   (brk_evt),
      .load_evt  (load_evt),
      .done_evt  (done_evt)
   );

   lin_hdr_flags #(
      .SET_WINS (SET_WINS)
   ) flags_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .load_evt (load_evt),
      .brk_evt  (brk_evt),
      .done_evt (done_evt),
      .sta_clr  (sta_clr),
      .tx_rdy   (tx_rdy),
      .brk_flag (brk_flag),
      .id_flag  (id_flag)
   );
endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic id_we,
   input logic sta_clr,
   input logic baud_tick,
   input logic hdr_busy,
   input logic txd,
   input logic tx_rdy,
   input logic brk_flag,
   input logic id_flag
);
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_busy |-> txd);

   a_r3_rdy_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (id_we && !hdr_busy) |=> (!tx_rdy && hdr_busy));

   a_r8_rdy_mid_header: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_rdy) |-> hdr_busy);

   a_r9_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !sta_clr) |=> brk_flag);

   a_r9_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (id_flag && !sta_clr) |=> id_flag);

   a_r6_id_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_flag) |-> (!hdr_busy && tx_rdy));

   a_r11_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_busy && !baud_tick) |=> $stable(txd));
endmodule

bind lin_hdr_tx lin_hdr_tx_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .id_we     (id_we),
   .sta_clr   (sta_clr),
   .baud_tick (baud_tick),
   .hdr_busy  (hdr_busy),
   .txd       (txd),
   .tx_rdy    (tx_rdy),
   .brk_flag  (brk_flag),
   .id_flag   (id_flag)
);

// File: tb/lin_hdr_tx_tb_top.sv
module lin_hdr_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       id_we = 1'b0;
   logic [7:0] id_wdata = 8'h00;
   logic       pid_en = 1'b0;
   logic       sta_clr = 1'b0;
   logic       txd, tx_rdy, brk_flag, id_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   lin_hdr_tx dut_i (
      .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick),
      .id_we (id_we), .id_wdata (id_wdata), .pid_en (pid_en),
      .sta_clr (sta_clr), .txd (txd), .tx_rdy (tx_rdy),
      .brk_flag (brk_flag), .id_flag (id_flag)
   );

   // {id, pid_en, expected sent byte}
   localparam logic [16:0] VEC [0:6] = '{
      {8'h00, 1'b1, 8'h80},
      {8'h3C, 1'b1, 8'h3C},
      {8'h12, 1'b1, 8'h92},
      {8'hFF, 1'b1, 8'hBF},
      {8'h01, 1'b1, 8'hC1},
      {8'hA5, 1'b0, 8'hA5},
      {8'h00, 1'b0, 8'h00}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one baud tick, optional clear on the same cycle; returns bit and the gap-cycle bit
   task automatic tick(input bit clr, output logic b, output logic g);
      @(negedge clk);
      baud_tick = 1'b1;
      sta_clr = clr;
      @(negedge clk);
      baud_tick = 1'b0;
      sta_clr = 1'b0;
      b = txd;
      @(negedge clk);
      g = txd;
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      sta_clr = 1'b1;
      @(negedge clk);
      sta_clr = 1'b0;
   endtask

   task automatic run_header(input logic [7:0] id, input bit pen, input logic [7:0] exp_id,
                             input int inject_at, input int clr_at);
      logic [35:1] line;
      logic        b, g;
      bit          hold_ok;
      logic [7:0]  sync_got, id_got;
      hold_ok = 1'b1;
      @(negedge clk);
      id_we = 1'b1;
      id_wdata = id;
      pid_en = pen;
      @(negedge clk);
      id_we = 1'b0;
      pid_en = 1'b0;
      check(tx_rdy == 1'b0, "R3 tx_rdy low after write", int'(tx_rdy), 0);
      for (int k = 1; k <= 35; k++) begin
         tick(k == clr_at, b, g);
         line[k] = b;
         if (g !== b) hold_ok = 1'b0;
         if (k == 14)
            check(brk_flag == 1'b0, "R9 brk_flag not before tick 15", int'(brk_flag), 0);
         if (k == 15)
            check(brk_flag == 1'b1, "R9 brk_flag at tick 15", int'(brk_flag), 1);
         if (k == 24)
            check(tx_rdy == 1'b0, "R8 tx_rdy low before tick 25", int'(tx_rdy), 0);
         if (k == 25)
            check(tx_rdy == 1'b1, "R8 tx_rdy high at tick 25", int'(tx_rdy), 1);
         if (k == 34)
            check(id_flag == 1'b0, "R9 id_flag not before tick 35", int'(id_flag), 0);
         if (k == inject_at) begin
            @(negedge clk);
            id_we = 1'b1;
            id_wdata = ~id;
            @(negedge clk);
            id_we = 1'b0;
            check(tx_rdy == (k >= 25), "R10 tx_rdy unaffected by busy write",
                  int'(tx_rdy), int'(k >= 25));
         end
      end
      check(line[13:1] == 13'h0000, "R4 break bits", int'(line[13:1]), 0);
      check(line[14] == 1'b1, "R4 delimiter", int'(line[14]), 1);
      for (int i = 0; i < 8; i++) sync_got[i] = line[16+i];
      check(line[15] == 1'b0 && line[24] == 1'b1 && sync_got == 8'h55, "R5 sync frame",
            int'({line[24], sync_got, line[15]}), int'({1'b1, 8'h55, 1'b0}));
      for (int i = 0; i < 8; i++) id_got[i] = line[26+i];
      check(line[25] == 1'b0 && line[34] == 1'b1, "R6 id framing",
            int'({line[34], line[25]}), 2);
      check(id_got == exp_id, (inject_at > 0) ? "R10 id byte kept" : "R7 id byte sent",
            int'(id_got), int'(exp_id));
      check(line[35] == 1'b1 && id_flag == 1'b1, "R6 end of header, R9 id_flag set",
            int'({line[35], id_flag}), 3);
      check(hold_ok, "R11 line held between ticks", int'(hold_ok), 1);
      // one more tick: line must stay idle
      tick(1'b0, b, g);
      check(b == 1'b1 && tx_rdy == 1'b1, "R2 idle after header", int'({b, tx_rdy}), 3);
   endtask

   initial begin
      logic b, g;
      repeat (3) @(negedge clk);
      check(txd == 1'b1 && tx_rdy == 1'b1 && brk_flag == 1'b0 && id_flag == 1'b0,
            "R1 reset state", int'({txd, tx_rdy, brk_flag, id_flag}), 4'b1100);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         tick(1'b0, b, g);
         check(b == 1'b1 && g == 1'b1, "R2 idle with ticks", int'({b, g}), 3);
      end

      for (int v = 0; v < 7; v++) begin
         run_header(VEC[v][16:9], VEC[v][8], VEC[v][7:0], 0, 0);
         pulse_clear();
         check(brk_flag == 1'b0 && id_flag == 1'b0, "R9 flags cleared by sta_clr",
               int'({brk_flag, id_flag}), 0);
      end

      // busy write in the break, then in the identifier field
      run_header(8'h3C, 1'b0, 8'h3C, 5, 0);
      pulse_clear();
      run_header(8'h12, 1'b1, 8'h92, 28, 0);
      // flags survive without a clear
      check(brk_flag == 1'b1 && id_flag == 1'b1, "R9 flags sticky", int'({brk_flag, id_flag}), 3);
      pulse_clear();

      // clear on the same cycle as tick 35: id set wins, brk cleared
      run_header(8'hA5, 1'b0, 8'hA5, 0, 35);
      check(brk_flag == 1'b0, "R9 clear on tick 35 drops brk_flag", int'(brk_flag), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule